// File: doc/BRIEF.md
# Ethernet Start-of-Frame Delimiter Detector

This block sits on a 4-bit nibble stream in the media-independent interface clock domain. It watches the nibble bus together with its frame qualifier, which is the transmit enable on the send side or the receive data-valid on the receive side. It reports the exact point where an Ethernet frame leaves its preamble and begins its data. The nibble history covers a full 16-nibble window on all four data lines, so no single wire or edge decides the result.

A small frame-start controller allows detection only between the rising edge of the qualifier and the first delimiter. Once the delimiter has been found, or the preamble has been broken, the block ignores everything until the qualifier falls. A preamble-like run inside the payload therefore never produces a second detection. The output is a single-cycle detect pulse and a flag that is high from that pulse to the end of the frame.

Top module: `sfd_detect`

## Requirements
- R1: Reset is synchronous and active-low. While it is sampled low and in the cycle after, `sof_o` and `in_frame_o` are 0, and the nibble history is cleared.
- R2: A frame starts on the first nibble sampled with `dv_i` high after it was low. If that frame delivers at least 15 nibbles of value 4'h5 (bit 0 = first bit on the wire) followed by 4'hD, `sof_o` is 1 for exactly one cycle. That cycle is the one after the edge that samples 4'hD, and `in_frame_o` rises in the same cycle.
- R3: `in_frame_o` stays 1 while `dv_i` stays high. It returns to 0 in the cycle after an edge that samples `dv_i` low.
- R4: `sof_o` fires at most once per qualifier assertion. A run of 15 × 4'h5 then 4'hD inside the payload gives no pulse.
- R5: A frame with fewer than 15 × 4'h5 before the first 4'hD gives no pulse for the rest of that frame, even if a correct sequence follows.
- R6: A preamble nibble other than 4'h5 or the final 4'hD gives no pulse for the rest of that frame.
- R7: A drop of `dv_i` aborts the preamble. Nibbles from before the drop do not count toward the next frame's window.
- R8: A preamble longer than 15 nibbles of 4'h5, followed by 4'hD, is still detected.
- R9: Nibbles sampled with `dv_i` low never cause a pulse. This includes a 4'hD that arrives in the same cycle the qualifier falls.
- R10: If `dv_i` is already high when reset is released, that frame is not a frame start. No pulse is given until `dv_i` has fallen and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nib_i | input | 4 | Data nibble, bit 0 first on the wire |
| dv_i | input | 1 | Frame qualifier (transmit enable or receive data-valid) |
| sof_o | output | 1 | One-cycle delimiter-detected pulse |
| in_frame_o | output | 1 | High from the detect pulse until the qualifier falls |

## Verification
Two functions can fall in the same cycle. First, the detect pulse and the rise of the frame flag must coincide. The bench samples both in the cycle after 4'hD and requires them together. Second, the final delimiter nibble can arrive in the same cycle that the qualifier falls. The bench presents 15 × 4'h5 with the qualifier high and then 4'hD with it low. It expects no pulse and a low frame flag, because the falling qualifier must win over the pattern match.

// File: rtl/sfd_pkg.sv
// Shared constants and types for the delimiter detector.
// Assumes nibble bit 0 is the first bit on the wire.
package sfd_pkg;
    localparam int unsigned NIB_W    = 4;
    localparam int unsigned WIN_LEN  = 16;          // nibbles in the full check window
    localparam int unsigned HIST_LEN = WIN_LEN - 1; // stored stages; the live nibble completes the window
    localparam logic [NIB_W-1:0] PRE_NIB = 4'h5;
    localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_FRAME = 2'd2,
        ST_WAIT  = 2'd3
    } sfd_state_t;
endpackage

// File: rtl/sfd_history.sv
// Per-bit serial-in parallel-out nibble history.
// Stage 0 holds the newest stored nibble. Every stage is cleared on reset and
// on any cycle with the qualifier low, so the window only ever holds nibbles
// of the current frame.
module sfd_history #(
    parameter int unsigned W     = 4,
    parameter int unsigned DEPTH = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dv_i,
    input  logic [W-1:0]             nib_i,
    output logic [W-1:0][DEPTH-1:0]  hist_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [DEPTH-1:0] sr;
        // Shift one data line into its own history, or clear it outside a frame.
        always_ff @(posedge clk) begin
            if (!rst_n || !dv_i) sr <= '0;
            else                 sr <= {sr[DEPTH-2:0], nib_i[b]};
        end
        assign hist_o[b] = sr;
    end
endmodule

// File: rtl/sfd_match.sv
// Window comparator. For each data line it forms the window from the stored
// stages plus the live bit, and checks it against the expected preamble then
// delimiter pattern (a wide AND with the expected-zero positions inverted).
module sfd_match #(
    parameter int unsigned      W     = 4,
    parameter int unsigned      DEPTH = 15,
    parameter logic [W-1:0]     PRE   = 4'h5,
    parameter logic [W-1:0]     SFD   = 4'hD
) (
    input  logic [W-1:0][DEPTH-1:0] hist_i,
    input  logic [W-1:0]            nib_i,
    output logic                    match_o
);
    logic [W-1:0] bit_ok;

    for (genvar b = 0; b < W; b++) begin : g_cmp
        localparam logic [DEPTH:0] EXP = {{DEPTH{PRE[b]}}, SFD[b]};
        logic [DEPTH:0] win;
        assign win       = {hist_i[b], nib_i[b]};
        // All window positions agree with the expected value for this line.
        assign bit_ok[b] = &(~(win ^ EXP));
    end

    assign match_o = &bit_ok;
endmodule

// File: rtl/sfd_ctrl.sv
// Frame-start controller. It arms matching only from the qualifier's rising
// edge until the first delimiter or a broken preamble, then waits for the
// qualifier to fall. The detect pulse and the frame flag are registered.
module sfd_ctrl
    import sfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dv_i,
    input  logic [NIB_W-1:0] nib_i,
    input  logic             match_i,
    output logic             sof_o,
    output logic             in_frame_o
);
    sfd_state_t state_q, state_d;
    logic       dv_q;
    logic       sof_d;

    // Next-state choice for the frame-start sequence.
    always_comb begin
        state_d = state_q;
        sof_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (dv_i) state_d = (!dv_q && nib_i == PRE_NIB) ? ST_PRE : ST_WAIT;
            end
            ST_PRE: begin
                if (!dv_i) begin
                    state_d = ST_IDLE;
                end else if (match_i) begin
                    state_d = ST_FRAME;
                    sof_d   = 1'b1;
                end else if (nib_i != PRE_NIB) begin
                    state_d = ST_WAIT;
                end
            end
            ST_FRAME, ST_WAIT: begin
                if (!dv_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, qualifier history and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dv_q    <= 1'b1;   // a qualifier already high at release is not a frame start
            sof_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            dv_q    <= dv_i;
            sof_o   <= sof_d;
        end
    end

    assign in_frame_o = (state_q == ST_FRAME);
endmodule

// File: rtl/sfd_detect.sv
// Top level of the delimiter detector. It ties the nibble history, the window
// comparator and the frame-start controller together. It assumes every input
// is synchronous to clk.
module sfd_detect
    import sfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] nib_i,
    input  logic             dv_i,
    output logic             sof_o,
    output logic             in_frame_o
);
    logic [NIB_W-1:0][HIST_LEN-1:0] hist;
    logic                           win_match;

    sfd_history #(.W(NIB_W), .DEPTH(HIST_LEN)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .dv_i   (dv_i),
        .nib_i  (nib_i),
        .hist_o (hist)
    );

    sfd_match #(.W(NIB_W), .DEPTH(HIST_LEN), .PRE(PRE_NIB), .SFD(SFD_NIB)) u_match (
        .hist_i  (hist),
        .nib_i   (nib_i),
        .match_o (win_match)
    );

    sfd_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dv_i       (dv_i),
        .nib_i      (nib_i),
        .match_i    (win_match),
        .sof_o      (sof_o),
        .in_frame_o (in_frame_o)
    );
endmodule

// File: rtl/sfd_detect_chk.sv
// Port-level temporal checks for the delimiter detector, bound to the top.
module sfd_detect_chk
    import sfd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NIB_W-1:0] nib_i,
    input logic             dv_i,
    input logic             sof_o,
    input logic             in_frame_o
);
    // R2
    sof_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> in_frame_o);
    // R2
    sof_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |=> !sof_o);
    // R2
    sof_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> ($past(dv_i) && $past(nib_i) == SFD_NIB));
    // R3
    frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame_o && !dv_i) |=> !in_frame_o);
    // R3
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame_o && dv_i) |=> in_frame_o);
    // R4
    single_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame_o && dv_i) |=> !sof_o);
    // R9
    idle_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dv_i |=> !sof_o);
endmodule

bind sfd_detect sfd_detect_chk u_sfd_detect_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .nib_i      (nib_i),
    .dv_i       (dv_i),
    .sof_o      (sof_o),
    .in_frame_o (in_frame_o)
);

// File: tb/sfd_detect_bench.sv
`timescale 1ns/1ps
module sfd_detect_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] nib_i = 4'h0;
    logic       dv_i = 1'b0;
    logic       sof_o, in_frame_o;
    int         n_chk = 0;
    int         n_bad = 0;
    int         pulses = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    sfd_detect u_sfd_detect (
        .clk(clk), .rst_n(rst_n), .nib_i(nib_i), .dv_i(dv_i),
        .sof_o(sof_o), .in_frame_o(in_frame_o)
    );

    // Count detect pulses, sampled away from the active edge.
    always @(negedge clk) if (sof_o === 1'b1) pulses++;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one nibble at the falling edge; return just after the sampling edge.
    task automatic nib(logic [3:0] n, logic d);
        @(negedge clk);
        nib_i = n;
        dv_i  = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) nib(4'h0, 1'b0);
    endtask

    task automatic fives(int n);
        for (int i = 0; i < n; i++) nib(4'h5, 1'b1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        chk("R1 sof after reset", sof_o, 0);
        chk("R1 in_frame after reset", in_frame_o, 0);
        rst_n = 1'b1;
        idle(2);
    endtask

    task automatic t_basic();
        int p0 = pulses;
        fives(15);
        chk("R2 no early pulse", pulses - p0, 0);
        nib(4'hD, 1'b1);
        chk("R2 sof in cycle after delimiter", sof_o, 1);
        chk("R2 in_frame rises with sof", in_frame_o, 1);
        nib(4'hA, 1'b1);
        chk("R2 sof one cycle wide", sof_o, 0);
        chk("R3 in_frame held", in_frame_o, 1);
        nib(4'h3, 1'b1);
        nib(4'h0, 1'b0);
        chk("R3 in_frame clears after drop", in_frame_o, 0);
        idle(2);
    endtask

    task automatic t_payload();
        int p0 = pulses;
        fives(15); nib(4'hD, 1'b1);
        fives(15); nib(4'hD, 1'b1); nib(4'h1, 1'b1);
        chk("R4 single pulse per frame", pulses - p0, 1);
        chk("R4 still in frame", in_frame_o, 1);
        idle(2);
    endtask

    task automatic t_short();
        int p0 = pulses;
        fives(14); nib(4'hD, 1'b1);
        fives(15); nib(4'hD, 1'b1); nib(4'h1, 1'b1);
        chk("R5 short preamble no pulse", pulses - p0, 0);
        chk("R5 not in frame", in_frame_o, 0);
        idle(2);
    endtask

    task automatic t_corrupt();
        int p0 = pulses;
        fives(7); nib(4'h7, 1'b1); fives(7); nib(4'hD, 1'b1);
        fives(15); nib(4'hD, 1'b1); nib(4'h1, 1'b1);
        chk("R6 broken preamble no pulse", pulses - p0, 0);
        idle(2);
    endtask

    task automatic t_gap();
        int p0 = pulses;
        fives(8); idle(1); fives(7); nib(4'hD, 1'b1); nib(4'h1, 1'b1);
        chk("R7 history cleared by gap", pulses - p0, 0);
        idle(2);
        fives(15); nib(4'hD, 1'b1);
        chk("R7 next frame detected", sof_o, 1);
        idle(2);
    endtask

    task automatic t_long();
        int p0 = pulses;
        fives(21); nib(4'hD, 1'b1);
        chk("R8 long preamble detected", sof_o, 1);
        nib(4'h2, 1'b1);
        chk("R8 one pulse", pulses - p0, 1);
        idle(2);
    endtask

    task automatic t_dvlow();
        int p0 = pulses;
        for (int i = 0; i < 15; i++) nib(4'h5, 1'b0);
        nib(4'hD, 1'b0); idle(1);
        chk("R9 nibbles with dv low ignored", pulses - p0, 0);
        fives(15); nib(4'hD, 1'b0);
        chk("R9 delimiter on falling dv no pulse", sof_o, 0);
        chk("R9 delimiter on falling dv no frame", in_frame_o, 0);
        idle(2);
    endtask

    task automatic t_reset_mid();
        int p0;
        fives(20); nib(4'hD, 1'b1);
        chk("R1 in frame before reset", in_frame_o, 1);
        rst_n = 1'b0; nib(4'h5, 1'b1);
        chk("R1 reset clears in_frame", in_frame_o, 0);
        rst_n = 1'b1;
        p0 = pulses;
        fives(15); nib(4'hD, 1'b1); nib(4'h1, 1'b1);
        chk("R10 no start while dv already high", pulses - p0, 0);
        idle(2);
        fives(15); nib(4'hD, 1'b1);
        chk("R10 detection after dv toggles", sof_o, 1);
        idle(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_basic();
        t_payload();
        t_short();
        t_corrupt();
        t_gap();
        t_long();
        t_dvlow();
        t_reset_mid();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule